// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block derives the horizontal, vertical and composite sync and blanking waveforms of a raster display from a single pixel clock. Every edge position is a 12-bit count held in a bank of eighteen timing words, and an 11-bit control word chooses the framing mode and the output polarities. It also selects what each of the four output pins carries and can stop the whole generator. The timing words and the control word come in as parallel inputs from a register file elsewhere on the chip. The generator only compares its counters against them.

A horizontal counter walks the pixels of a line and a vertical counter walks lines (or half-lines when interlaced). Range comparators turn the two counts into sync, blank, gate, cursor and interrupt pulses. Composite sync can carry equalization and serration notches at twice the line rate inside a programmed band of lines. Registers clocked on the falling edge of the clock drive the four pins and the field flag. A restart input returns the raster to the first clock of the odd field, so the generator can be aligned to an outside event.

Timing word k (k = 1..18) occupies bits [(k-1)*12 +: 12] of `tregs_i`. These words are called T1..T18 below.

Top module: `vsync_timing_gen`

## Requirements
- R1: The horizontal count runs 1, 2, …, T4 and then returns to 1, advancing once per enabled falling clock edge. T4 must be even. It is 1 after reset.
- R2: Horizontal blank is active while the horizontal count lies in [1, T3), which is T3-1 clocks. Horizontal sync is active in [T1, T2), which is T2-T1 clocks. Horizontal gate is active in [T15, T16).
- R3: The vertical count runs 1..T8 and then returns to 1. It steps when the horizontal count leaves T4. In interlaced mode it also steps when the horizontal count leaves T4/2, so it counts half-lines. Vertical blank is active in [1, T7), vertical gate in [T17, T18), and the vertical interrupt in [T13, T14).
- R4: The vertical sync state is re-evaluated as active in [T5, T6) only when the horizontal count enters T1 (and, when interlaced, T1+T4/2), which is the leading edge of horizontal sync. A restart clears it unless that same edge is such a leading edge.
- R5: Composite blank is horizontal blank OR vertical blank, and composite sync is horizontal sync OR vertical sync (taken active-high). The cursor is the horizontal gate AND the vertical gate.
- R6: When control bit 9 is 0 and the vertical count lies in [T11, T12), composite sync is replaced by notch pulses. The position p is the horizontal count, minus T4/2 in double-rate modes when the count exceeds T4/2. While vertical sync is active, sync is on for p in [T1, T10) (serration). Otherwise it is on for p in [T1, T9) (equalization). Control bit 9 set to 1 removes both.
- R7: Control bits [4:3] set the mode. 00 is interlaced with double-rate equalization and serration. 01 is non-interlaced with double-rate serration; there, equalization lines carry plain horizontal sync. 11 is non-interlaced with single-rate equalization and serration. 10 behaves as 11.
- R8: The field flag toggles each time the vertical count wraps in interlaced mode. It is forced high on the next enabled edge in non-interlaced modes, and it is high after reset.
- R9: With control bit 10 at 0, counters, the vertical sync state, pins and the field flag all hold their values.
- R10: Control bits 5, 6, 7 and 8 set the polarity of the blank pin, sync pin, horizontal-aux pin and vertical-aux pin. A 1 drives the pin high when its signal is active, and a 0 drives it low.
- R11: Control bits [2:0] = {s2,s1,s0} route the signals. The blank pin carries vertical blank if s0, else composite blank. The sync pin carries vertical sync if s1, else composite sync. The horizontal-aux pin carries horizontal blank if s0, else the cursor if s2, else the horizontal gate. The vertical-aux pin carries horizontal sync if s1, else the vertical interrupt if s2, else the vertical gate.
- R12: A count beyond its end value runs on to 4095, rolls over to 0 and counts up again until it meets the end value.
- R13: With restart_i high on an enabled edge, both counts become 1 and the field flag becomes 1 (the odd field).
- R14: Pins change only on the falling clock edge and show the waveforms of the counter state held before that edge. During reset all four pins are low and the field flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock; state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 11 | Control word: route, mode, polarity, notch disable, run |
| tregs_i | input | 216 | Eighteen 12-bit timing words T1..T18 |
| restart_i | input | 1 | Return to the start of the odd field on the next enabled edge |
| blank_pin_o | output | 1 | Vertical or composite blank |
| sync_pin_o | output | 1 | Vertical or composite sync |
| haux_pin_o | output | 1 | Horizontal blank, horizontal gate or cursor |
| vaux_pin_o | output | 1 | Horizontal sync, vertical gate or vertical interrupt |
| field_odd_o | output | 1 | High in the odd field and in non-interlaced modes |

## Verification
Restart can land on the same edge as a horizontal or vertical wrap, or on an edge where the run bit is low. Restart must win over the wrap, and a stopped clock must win over restart. The bench provokes these cases by raising restart at random while the run bit also drops at random across many random register sets. A reference model computed in the bench from the requirements judges every pin and the field flag on every cycle.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  parameter int unsigned TW    = 12;
  parameter int unsigned NSLOT = 18;
  parameter int unsigned CW    = 11;

  typedef logic [TW-1:0] tval_t;

  typedef struct packed {
    logic       run;
    logic       es_off;
    logic [3:0] pol;
    logic       il;
    logic       dbl;
    logic       eq_on;
    logic [2:0] sel;
  } mode_t;

  function automatic mode_t decode_mode(input logic [CW-1:0] c);
    mode_t m;
    m.run    = c[10];
    m.es_off = c[9];
    m.pol    = c[8:5];
    m.sel    = c[2:0];
    m.il     = (c[4:3] == 2'b00);
    m.dbl    = !c[4];
    m.eq_on  = (c[4:3] != 2'b01);
    return m;
  endfunction

  function automatic logic in_span(input tval_t x, input tval_t lo, input tval_t hi);
    return (x >= lo) && (x < hi);
  endfunction
endpackage

// File: rtl/vsg_hcount.sv
module vsg_hcount
  import vsg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  restart_i,
  input  logic  il_i,
  input  logic  dbl_i,
  input  tval_t hmax_i,
  output tval_t hcnt_o,
  output tval_t hnext_o,
  output tval_t pos_o,
  output tval_t half_o,
  output logic  step_o
);
  tval_t hcnt_q, hcnt_d, half;

  assign half = hmax_i >> 1;

  always_comb begin
    hcnt_d = hcnt_q;
    if (run_i) begin
      if (restart_i)              hcnt_d = tval_t'(1);
      else if (hcnt_q == hmax_i)  hcnt_d = tval_t'(1);
      else                        hcnt_d = tval_t'(hcnt_q + 1'b1);
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hcnt_q <= tval_t'(1);
    else         hcnt_q <= hcnt_d;
  end

  assign hcnt_o  = hcnt_q;
  assign hnext_o = hcnt_d;
  assign half_o  = half;
  assign pos_o   = (dbl_i && (hcnt_q > half)) ? tval_t'(hcnt_q - half) : hcnt_q;
  assign step_o  = run_i && !restart_i &&
                   ((hcnt_q == hmax_i) || (il_i && (hcnt_q == half)));

  assert_hstep_R1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (run_i && !restart_i && hcnt_q != hmax_i) |=> hcnt_q == tval_t'($past(hcnt_q) + 1'b1));

  assert_hfreeze_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(hcnt_q));

  assert_hrestart_R13: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (run_i && restart_i) |=> hcnt_q == tval_t'(1));
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount
  import vsg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  restart_i,
  input  logic  il_i,
  input  logic  step_i,
  input  tval_t vmax_i,
  input  tval_t hcnt_i,
  input  tval_t hnext_i,
  input  tval_t half_i,
  input  tval_t r1_i,
  input  tval_t r5_i,
  input  tval_t r6_i,
  output tval_t vcnt_o,
  output logic  odd_o,
  output logic  vsync_o
);
  tval_t vcnt_q, vcnt_d;
  logic  odd_q, odd_d, vs_q, vs_d, hs_lead;
  tval_t lead2;

  assign lead2   = tval_t'(r1_i + half_i);
  assign hs_lead = (hnext_i == r1_i) || (il_i && (hnext_i == lead2));

  always_comb begin
    vcnt_d = vcnt_q;
    odd_d  = odd_q;
    vs_d   = vs_q;
    if (run_i) begin
      if (restart_i) begin
        vcnt_d = tval_t'(1);
        odd_d  = 1'b1;
      end else if (step_i) begin
        if (vcnt_q == vmax_i) begin
          vcnt_d = tval_t'(1);
          odd_d  = !odd_q;
        end else begin
          vcnt_d = tval_t'(vcnt_q + 1'b1);
        end
      end
      if (!il_i) odd_d = 1'b1;
      if (hs_lead)        vs_d = in_span(vcnt_d, r5_i, r6_i);
      else if (restart_i) vs_d = 1'b0;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q <= tval_t'(1);
      odd_q  <= 1'b1;
      vs_q   <= 1'b0;
    end else begin
      vcnt_q <= vcnt_d;
      odd_q  <= odd_d;
      vs_q   <= vs_d;
    end
  end

  assign vcnt_o  = vcnt_q;
  assign odd_o   = odd_q;
  assign vsync_o = vs_q;

  assert_vwrap_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (step_i && vcnt_q == vmax_i) |=> vcnt_q == tval_t'(1));

  assert_odd_flat_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (run_i && !il_i) |=> odd_q);

  assert_vs_at_lead_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(vs_q) |-> (hcnt_i == r1_i) || (hcnt_i == tval_t'(1)) ||
                       (il_i && hcnt_i == tval_t'(r1_i + half_i)));
endmodule

// File: rtl/vsg_wave.sv
module vsg_wave
  import vsg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t md_i,
  input  tval_t hcnt_i,
  input  tval_t pos_i,
  input  tval_t vcnt_i,
  input  logic  vsync_i,
  input  tval_t r1_i,
  input  tval_t r2_i,
  input  tval_t r3_i,
  input  tval_t r7_i,
  input  tval_t r9_i,
  input  tval_t r10_i,
  input  tval_t r11_i,
  input  tval_t r12_i,
  input  tval_t r13_i,
  input  tval_t r14_i,
  input  tval_t r15_i,
  input  tval_t r16_i,
  input  tval_t r17_i,
  input  tval_t r18_i,
  output logic [3:0] pin_o
);
  localparam int unsigned NPIN = 4;
  localparam tval_t ONE = tval_t'(1);

  logic hsync, hblank, vblank, win, csync, cblank;
  logic hgate, vgate, cursor, vint;
  logic [NPIN-1:0] act, pin_val, pin_q, pin_d;

  assign hsync  = in_span(hcnt_i, r1_i, r2_i);
  assign hblank = in_span(hcnt_i, ONE, r3_i);
  assign vblank = in_span(vcnt_i, ONE, r7_i);
  assign hgate  = in_span(hcnt_i, r15_i, r16_i);
  assign vgate  = in_span(vcnt_i, r17_i, r18_i);
  assign vint   = in_span(vcnt_i, r13_i, r14_i);
  assign cursor = hgate && vgate;
  assign cblank = hblank || vblank;
  assign win    = !md_i.es_off && in_span(vcnt_i, r11_i, r12_i);

  always_comb begin
    if (win) begin
      if (vsync_i)         csync = in_span(pos_i, r1_i, r10_i);
      else if (md_i.eq_on) csync = in_span(pos_i, r1_i, r9_i);
      else                 csync = hsync;
    end else begin
      csync = hsync || vsync_i;
    end
  end

  always_comb begin
    act[0] = md_i.sel[0] ? vblank : cblank;
    act[1] = md_i.sel[1] ? vsync_i : csync;
    act[2] = md_i.sel[0] ? hblank : (md_i.sel[2] ? cursor : hgate);
    act[3] = md_i.sel[1] ? hsync  : (md_i.sel[2] ? vint   : vgate);
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pol
    assign pin_val[g] = md_i.pol[g] ? act[g] : !act[g];
  end

  assign pin_d = md_i.run ? pin_val : pin_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  assert_pin_hold_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !md_i.run |=> $stable(pin_q));

  assert_cursor_in_gate_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    cursor |-> (hcnt_i >= r15_i) && (vcnt_i >= r17_i));
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vsg_pkg::*;
#(
  parameter int unsigned SLOTS = vsg_pkg::NSLOT,
  parameter int unsigned WID   = vsg_pkg::TW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CW-1:0]         ctrl_i,
  input  logic [SLOTS*WID-1:0]  tregs_i,
  input  logic                  restart_i,
  output logic                  blank_pin_o,
  output logic                  sync_pin_o,
  output logic                  haux_pin_o,
  output logic                  vaux_pin_o,
  output logic                  field_odd_o
);
  tval_t tr [1:SLOTS];
  for (genvar k = 1; k <= SLOTS; k++) begin : g_slot
    assign tr[k] = tval_t'(tregs_i[(k-1)*WID +: WID]);
  end

  mode_t md;
  assign md = decode_mode(ctrl_i);

  tval_t hcnt, hnext, pos, half, vcnt;
  logic  step, vsync;
  logic [3:0] pins;

  vsg_hcount u_h (
    .clk_i, .rst_ni,
    .run_i(md.run), .restart_i, .il_i(md.il), .dbl_i(md.dbl),
    .hmax_i(tr[4]),
    .hcnt_o(hcnt), .hnext_o(hnext), .pos_o(pos), .half_o(half), .step_o(step)
  );

  vsg_vcount u_v (
    .clk_i, .rst_ni,
    .run_i(md.run), .restart_i, .il_i(md.il), .step_i(step),
    .vmax_i(tr[8]), .hcnt_i(hcnt), .hnext_i(hnext), .half_i(half),
    .r1_i(tr[1]), .r5_i(tr[5]), .r6_i(tr[6]),
    .vcnt_o(vcnt), .odd_o(field_odd_o), .vsync_o(vsync)
  );

  vsg_wave u_w (
    .clk_i, .rst_ni, .md_i(md),
    .hcnt_i(hcnt), .pos_i(pos), .vcnt_i(vcnt), .vsync_i(vsync),
    .r1_i(tr[1]), .r2_i(tr[2]), .r3_i(tr[3]), .r7_i(tr[7]),
    .r9_i(tr[9]), .r10_i(tr[10]), .r11_i(tr[11]), .r12_i(tr[12]),
    .r13_i(tr[13]), .r14_i(tr[14]), .r15_i(tr[15]), .r16_i(tr[16]),
    .r17_i(tr[17]), .r18_i(tr[18]),
    .pin_o(pins)
  );

  assign blank_pin_o = pins[0];
  assign sync_pin_o  = pins[1];
  assign haux_pin_o  = pins[2];
  assign vaux_pin_o  = pins[3];
endmodule

// File: tb/vsync_timing_gen_tb_top.sv
module vsync_timing_gen_tb_top;
  localparam int CLKP = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [10:0] ctrl;
  logic [215:0] tregs;
  logic restart;
  logic bp, sp, hp_, vp, fo;
  logic [11:0] rg [1:18];

  always #(CLKP/2) clk = ~clk;

  always_comb
    for (int k = 1; k <= 18; k++) tregs[(k-1)*12 +: 12] = rg[k];

  vsync_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .tregs_i(tregs), .restart_i(restart),
    .blank_pin_o(bp), .sync_pin_o(sp), .haux_pin_o(hp_), .vaux_pin_o(vp), .field_odd_o(fo)
  );

  int n_chk = 0, n_bad = 0;
  string cur_tag = "R1";

  // reference state
  logic [11:0] mh, mv;
  logic modd, mvs;
  logic [3:0] epin;

  function automatic logic sp_in(input logic [11:0] x, input logic [11:0] lo, input logic [11:0] hi);
    return (x >= lo) && (x < hi);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: got %b expected %b at %0t", tag, cur_tag, act, exp, $time);
    end
  endtask

  // expected pins from current reference state (R2 R3 R5 R6 R7 R10 R11)
  function automatic logic [3:0] ref_pins();
    logic il, dbl, eqon, hs, hb, vb, win, cs, hg, vg, vi, cur;
    logic [11:0] half, p;
    logic [3:0] a, o;
    il   = (ctrl[4:3] == 2'b00);
    dbl  = !ctrl[4];
    eqon = (ctrl[4:3] != 2'b01);
    half = rg[4] >> 1;
    p    = (dbl && mh > half) ? 12'(mh - half) : mh;
    hs = sp_in(mh, rg[1], rg[2]);
    hb = sp_in(mh, 12'd1, rg[3]);
    vb = sp_in(mv, 12'd1, rg[7]);
    hg = sp_in(mh, rg[15], rg[16]);
    vg = sp_in(mv, rg[17], rg[18]);
    vi = sp_in(mv, rg[13], rg[14]);
    cur = hg & vg;
    win = !ctrl[9] && sp_in(mv, rg[11], rg[12]);
    if (win) cs = mvs ? sp_in(p, rg[1], rg[10]) : (eqon ? sp_in(p, rg[1], rg[9]) : hs);
    else     cs = hs | mvs;
    a[0] = ctrl[0] ? vb : (hb | vb);
    a[1] = ctrl[1] ? mvs : cs;
    a[2] = ctrl[0] ? hb : (ctrl[2] ? cur : hg);
    a[3] = ctrl[1] ? hs : (ctrl[2] ? vi : vg);
    for (int g = 0; g < 4; g++) o[g] = ctrl[5+g] ? a[g] : !a[g];
    return o;
  endfunction

  // one clock: predict the falling edge, then compare after the next rising edge
  task automatic step();
    logic il, stp, lead;
    logic [11:0] half, nh, nv;
    if (ctrl[10]) begin
      il   = (ctrl[4:3] == 2'b00);
      half = rg[4] >> 1;
      epin = ref_pins();
      nh   = restart ? 12'd1 : ((mh == rg[4]) ? 12'd1 : 12'(mh + 1));   // R1 R12
      stp  = !restart && ((mh == rg[4]) || (il && mh == half));
      nv   = restart ? 12'd1 : (stp ? ((mv == rg[8]) ? 12'd1 : 12'(mv + 1)) : mv);
      if (restart) modd = 1'b1;
      else if (stp && mv == rg[8]) modd = !modd;
      if (!il) modd = 1'b1;
      lead = (nh == rg[1]) || (il && nh == 12'(rg[1] + half));
      if (lead) mvs = sp_in(nv, rg[5], rg[6]);
      else if (restart) mvs = 1'b0;
      mh = nh; mv = nv;
    end
    @(posedge clk); #1;
    chk("R5 R11 R14 blank pin", bp, epin[0]);
    chk("R4 R6 R7 sync pin", sp, epin[1]);
    chk("R2 R11 haux pin", hp_, epin[2]);
    chk("R3 R11 vaux pin", vp, epin[3]);
    chk("R8 field flag", fo, modd);
  endtask

  task automatic rand_regs();
    int h;
    rg[4]  = 12'(2 * (12 + $urandom % 18));
    h      = int'(rg[4]) / 2;
    rg[1]  = 12'(2 + $urandom % 3);
    rg[2]  = 12'(rg[1] + 2 + $urandom % 4);
    rg[3]  = 12'(rg[2] + 1 + $urandom % 4);
    rg[9]  = 12'(rg[1] + 1 + $urandom % 3);
    rg[10] = 12'(rg[1] + 2 + $urandom % (h - 4));
    rg[8]  = 12'(10 + $urandom % 16);
    rg[5]  = 12'(2 + $urandom % 3);
    rg[6]  = 12'(rg[5] + 1 + $urandom % 3);
    rg[7]  = 12'(rg[6] + 1 + $urandom % 3);
    rg[11] = 12'(1 + $urandom % 3);
    rg[12] = 12'(rg[6] + $urandom % 4);
    rg[13] = 12'(1 + $urandom % rg[8]);
    rg[14] = 12'(rg[13] + $urandom % 6);
    rg[15] = 12'(1 + $urandom % rg[4]);
    rg[16] = 12'(rg[15] + $urandom % 10);
    rg[17] = 12'(1 + $urandom % rg[8]);
    rg[18] = 12'(rg[17] + $urandom % 6);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLKP * 190000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [1:0] mlist [4];
    int gap, nhs, nhb;
    logic prev;
    mlist[0] = 2'b00; mlist[1] = 2'b01; mlist[2] = 2'b11; mlist[3] = 2'b10;
    void'($urandom(32'd715));
    rst_n = 1'b0; restart = 1'b0; ctrl = '0;
    for (int k = 1; k <= 18; k++) rg[k] = 12'd1;
    mh = 12'd1; mv = 12'd1; modd = 1'b1; mvs = 1'b0; epin = '0;
    repeat (3) @(posedge clk);
    #1;
    cur_tag = "R14 reset";
    chk("R14 reset pins", |{bp, sp, hp_, vp}, 1'b0);
    chk("R14 reset field", fo, 1'b1);
    rst_n = 1'b1;

    // directed widths: non-interlaced single, pins active high, separate signals
    rg[1] = 12'd4; rg[2] = 12'd10; rg[3] = 12'd14; rg[4] = 12'd40;
    rg[5] = 12'd3; rg[6] = 12'd5; rg[7] = 12'd7; rg[8] = 12'd12;
    rg[9] = 12'd7; rg[10] = 12'd18; rg[11] = 12'd1; rg[12] = 12'd8;
    ctrl = {1'b1, 1'b0, 4'b1111, 2'b11, 3'b011};
    cur_tag = "R1 R2 widths";
    prev = 1'b1;
    for (int i = 0; i < 200; i++) begin
      prev = hp_; step();
      if (!prev && hp_) break;
    end
    gap = 1; nhb = int'(hp_); nhs = int'(vp);
    for (int i = 0; i < 200; i++) begin
      prev = hp_; step();
      if (!prev && hp_) break;
      gap++; nhb += int'(hp_); nhs += int'(vp);
    end
    n_chk++; if (gap != 40)  begin n_bad++; $display("FAIL R1 line period: got %0d expected 40", gap); end
    n_chk++; if (nhb != 13)  begin n_bad++; $display("FAIL R2 hblank width: got %0d expected 13", nhb); end
    n_chk++; if (nhs != 6)   begin n_bad++; $display("FAIL R2 hsync width: got %0d expected 6", nhs); end

    // clock disabled: pins and flag must hold (R9)
    cur_tag = "R9 hold";
    ctrl[10] = 1'b0;
    prev = sp;
    for (int i = 0; i < 30; i++) step();
    chk("R9 sync held", sp, prev);
    ctrl[10] = 1'b1;

    // overrun: lower the line end below the current count (R12)
    cur_tag = "R12 overrun";
    while (mh != 12'd30) step();
    rg[4] = 12'd20;
    for (int i = 0; i < 4150; i++) step();
    rg[4] = 12'd40;

    // restart in interlaced mode lands on odd field (R13)
    cur_tag = "R13 restart";
    ctrl[4:3] = 2'b00;
    for (int i = 0; i < 700; i++) step();
    restart = 1'b1; step(); restart = 1'b0;
    chk("R13 odd after restart", fo, 1'b1);
    for (int i = 0; i < 200; i++) step();

    // random register sets, modes, routes and polarities
    for (int c = 0; c < 24; c++) begin
      cur_tag = "R1 R3 R6 R7 R9 R10 R11 R13 random";
      ctrl[10] = 1'b0; step();
      rand_regs();
      ctrl[2:0] = 3'($urandom % 8);
      ctrl[4:3] = mlist[$urandom % 4];
      ctrl[8:5] = 4'($urandom % 16);
      ctrl[9]   = ($urandom % 4 == 0);
      ctrl[10]  = 1'b1;
      restart = 1'b1; step(); restart = 1'b0;
      for (int i = 0; i < int'(rg[4]) * int'(rg[8]) + 60; i++) begin
        ctrl[10] = ($urandom % 16 != 0);
        restart  = ($urandom % 600 == 0);
        step();
      end
      restart = 1'b0; ctrl[10] = 1'b1;
    end

    summary();
    $finish;
  end
endmodule